// File: doc/BRIEF.md
# Late-Sampling Timing Error Detector Register Bank

This block is a bank of pipeline registers that keep working when the supply is lowered close to the point where paths start to miss timing. Each monitored bit is captured twice. A main register takes the data on the rising edge of the normal clock. A shadow latch follows the same data while a delayed copy of that clock is high, so it keeps the value of data that arrives late but still inside the safety margin. At the next rising edge the two copies are compared bit by bit.

A disagreement means the main register took a stale value. When that happens the bank does four things. It keeps its forwarded output unchanged, it reloads the main register from the shadow latch, it raises a one-cycle stall towards the upstream stage, and it releases the corrected word one cycle later. The per-bit flags are merged by an OR tree into one system error. That error also acts as a request to the voltage/frequency controller. A saturating counter records how many cycles the system error was high. A parameter mask chooses which bits carry a shadow latch; the other bits are plain registers.

Top module: `timing_err_detector`

## Requirements
- R1: Without errors, a word on `data_in` at a rising `clk` edge is loaded into the main register and appears on `data_out` after the next rising edge.
- R2: The shadow latch of a monitored bit follows `data_in` only while `clk_dly` is high and keeps its value while `clk_dly` is low. A change of `data_in` inside that window, after the main register has sampled, therefore produces a mismatch.
- R3: At each rising edge outside a correction cycle, bit i of `err_bits` is loaded with the XOR of main register i and shadow latch i, for every monitored bit.
- R4: A bit whose `MONITOR_MASK` bit is 0 has no shadow latch and its `err_bits` bit is always 0. At a correction edge it keeps its current value.
- R5: `sys_err` is the OR of all bits of `err_bits`, and `vf_req` equals `sys_err`.
- R6: At an edge where any mismatch is found, `data_out` keeps its value and each monitored main register is reloaded from its shadow latch. The `data_in` word present at that edge is not loaded.
- R7: After a detection edge, `stall` is high for exactly one cycle. At the edge that ends that cycle, `data_out` takes the corrected word, the main registers load `data_in`, `err_bits` clears, and no comparison is made.
- R8: `err_cnt` increments at every rising edge that closes a cycle in which `sys_err` was high. It stops at its maximum value.
- R9: `cnt_clr` high at a rising edge sets `err_cnt` to 0, and this takes priority over incrementing.
- R10: `rst_n` low at a rising edge clears the main registers, `data_out`, `err_bits`, `stall` and `err_cnt`. `rst_n` low while `clk_dly` is high clears the shadow latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Normal clock; main registers sample on its rising edge |
| clk_dly | input | 1 | Delayed clock; shadow latches are open while it is high |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | DATA_W | Data from the upstream logic |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| data_out | output | DATA_W | Verified data forwarded to the next stage |
| err_bits | output | DATA_W | Registered per-bit mismatch flags |
| sys_err | output | 1 | OR of all per-bit flags |
| vf_req | output | 1 | Request to raise voltage or lower frequency |
| stall | output | 1 | High for the single correction cycle after a detection |
| err_cnt | output | CNT_W | Saturating count of cycles with `sys_err` high |

## Verification
The hardest situation to reach is a genuine late arrival. The data must change after the main register has sampled but before the delayed clock closes the shadow latch, and it must do so in a particular bit and sometimes during the correction cycle itself. The bench drives each word shortly before the normal edge. It then changes selected bits a few time units after that edge, inside the delayed-clock window. These late flips are random, mixed with directed cases: a flip on the unmonitored bit, a flip during a stall, and back-to-back errors that drive the counter into saturation.

// File: rtl/tdet_pkg.sv
// Shared definitions for the timing error detector bank.
// Assumes: nothing beyond IEEE 1800-2017.
package tdet_pkg;

    // Control phase of the bank: normal running or the single correction cycle.
    typedef enum logic {
        PH_RUN = 1'b0,
        PH_FIX = 1'b1
    } tdet_phase_e;

endpackage

// File: rtl/tdet_shadow_slice.sv
// One monitored bit: main flop on the normal clock plus a shadow latch open
// while the delayed clock is high, and a mismatch comparator.
// Assumes: clk_dly lags clk by less than half a period, so the latch is closed
// at every rising edge of clk.
module tdet_shadow_slice (
    input  logic clk,
    input  logic clk_dly,
    input  logic rst_n,
    input  logic data_i,
    input  logic fix_i,
    input  logic cmp_en_i,
    output logic q_o,
    output logic mism_o
);

    logic main_q;
    logic shadow_q;

    // Main register: takes the input, or the shadow copy on a correction edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= 1'b0;
        end else if (fix_i) begin
            main_q <= shadow_q;
        end else begin
            main_q <= data_i;
        end
    end

    // Shadow latch: transparent while the delayed clock is high.
    always_latch begin
        if (clk_dly) begin
            shadow_q = rst_n ? data_i : 1'b0;
        end
    end

    // Comparator: bitwise disagreement, only when comparison is enabled.
    assign mism_o = cmp_en_i & (main_q ^ shadow_q);
    assign q_o    = main_q;

endmodule

// File: rtl/tdet_or_tree.sv
// OR reduction of a flag vector into a single flag.
// Assumes: WIDTH >= 1.
module tdet_or_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             any_o
);

    localparam int HALF = WIDTH / 2;

    generate
        if (WIDTH == 1) begin : g_leaf
            // Single input passes straight through.
            assign any_o = vec_i[0];
        end else begin : g_split
            logic lo_any;
            logic hi_any;
            tdet_or_tree #(.WIDTH(HALF)) u_lo (
                .vec_i(vec_i[HALF-1:0]),
                .any_o(lo_any)
            );
            tdet_or_tree #(.WIDTH(WIDTH - HALF)) u_hi (
                .vec_i(vec_i[WIDTH-1:HALF]),
                .any_o(hi_any)
            );
            // Combine the two halves.
            assign any_o = lo_any | hi_any;
        end
    endgenerate

endmodule

// File: rtl/tdet_err_counter.sv
// Saturating counter of cycles in which the system error was high.
// Assumes: clear has priority over counting.
module tdet_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Count up on each error cycle and stop at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/timing_err_detector.sv
// Bank of DATA_W speculative pipeline registers with shadow-latch error
// detection, one-cycle hold-and-correct recovery, error aggregation and a
// saturating error counter.
// Assumes: clk_dly is clk delayed by a fixed margin shorter than half a
// period; upstream re-presents its word when stall is high.
module timing_err_detector #(
    parameter int                 DATA_W       = 8,
    parameter logic [DATA_W-1:0]  MONITOR_MASK = {DATA_W{1'b1}},
    parameter int                 CNT_W        = 16
) (
    input  logic              clk,
    input  logic              clk_dly,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              cnt_clr,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] err_bits,
    output logic              sys_err,
    output logic              vf_req,
    output logic              stall,
    output logic [CNT_W-1:0]  err_cnt
);

    import tdet_pkg::*;

    tdet_phase_e       phase_q;
    logic [DATA_W-1:0] main_vec;
    logic [DATA_W-1:0] mism_vec;
    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] out_q;
    logic              cmp_en;
    logic              fix;
    logic              flags_any;

    // Comparison is made only outside the correction cycle.
    assign cmp_en = (phase_q == PH_RUN);

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            if (MONITOR_MASK[i]) begin : g_mon
                tdet_shadow_slice u_slice (
                    .clk     (clk),
                    .clk_dly (clk_dly),
                    .rst_n   (rst_n),
                    .data_i  (data_in[i]),
                    .fix_i   (fix),
                    .cmp_en_i(cmp_en),
                    .q_o     (main_vec[i]),
                    .mism_o  (mism_vec[i])
                );
            end else begin : g_plain
                logic plain_q;
                // Plain register: holds on a correction edge, else loads input.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        plain_q <= 1'b0;
                    end else if (!fix) begin
                        plain_q <= data_in[i];
                    end
                end
                assign main_vec[i] = plain_q;
                assign mism_vec[i] = 1'b0;
            end
        end
    endgenerate

    // Any live mismatch triggers correction at this edge.
    tdet_or_tree #(.WIDTH(DATA_W)) u_mism_or (
        .vec_i(mism_vec),
        .any_o(fix)
    );

    // Registered flags merged into the system error.
    tdet_or_tree #(.WIDTH(DATA_W)) u_flag_or (
        .vec_i(flags_q),
        .any_o(flags_any)
    );

    // Phase, flags and forwarded output update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RUN;
            flags_q <= '0;
            out_q   <= '0;
        end else begin
            flags_q <= mism_vec;
            phase_q <= fix ? PH_FIX : PH_RUN;
            if (!fix) begin
                out_q <= main_vec;
            end
        end
    end

    tdet_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(cnt_clr),
        .inc_i(flags_any),
        .cnt_o(err_cnt)
    );

    assign data_out = out_q;
    assign err_bits = flags_q;
    assign sys_err  = flags_any;
    assign vf_req   = flags_any;
    assign stall    = (phase_q == PH_FIX);

endmodule

// File: rtl/tdet_checker.sv
// Property checker for the timing error detector, attached by bind.
// Assumes: the same parameters as the bound instance.
module tdet_checker #(
    parameter int                 DATA_W       = 8,
    parameter logic [DATA_W-1:0]  MONITOR_MASK = {DATA_W{1'b1}},
    parameter int                 CNT_W        = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic [DATA_W-1:0] data_out,
    input logic [DATA_W-1:0] err_bits,
    input logic              sys_err,
    input logic              vf_req,
    input logic              stall,
    input logic [CNT_W-1:0]  err_cnt
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    AST_HOLD_ON_DETECT: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> $stable(data_out)); // R6
    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall); // R7
    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (err_bits == '0)); // R7
    AST_UNMON_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (err_bits & ~MONITOR_MASK) == '0); // R4
    AST_ERR_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n) sys_err |-> (stall && vf_req)); // R5
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (err_cnt == CNT_TOP && !cnt_clr) |=> err_cnt == CNT_TOP); // R8
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!sys_err && !cnt_clr) |=> $stable(err_cnt)); // R8
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) cnt_clr |=> err_cnt == '0); // R9
    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (err_cnt == '0 && !stall && data_out == '0 && err_bits == '0)); // R10

endmodule

bind timing_err_detector tdet_checker #(
    .DATA_W      (DATA_W),
    .MONITOR_MASK(MONITOR_MASK),
    .CNT_W       (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_clr (cnt_clr),
    .data_out(data_out),
    .err_bits(err_bits),
    .sys_err (sys_err),
    .vf_req  (vf_req),
    .stall   (stall),
    .err_cnt (err_cnt)
);

// File: tb/tb_timing_err_detector.sv
// Self-checking bench: random and directed late arrivals against a
// requirement-level model.
module tb_timing_err_detector;

    localparam int          CLK_PERIOD = 10;
    localparam int          DLY        = 2;
    localparam int          W          = 8;
    localparam logic [W-1:0] MASK      = 8'hBF;
    localparam int          CW         = 5;
    localparam logic [CW-1:0] CMAX     = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          clk_dly = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic          cnt_clr = 1'b0;
    logic [W-1:0]  data_out;
    logic [W-1:0]  err_bits;
    logic          sys_err;
    logic          vf_req;
    logic          stall;
    logic [CW-1:0] err_cnt;

    int checks = 0;
    int fails  = 0;

    // Model state.
    logic [W-1:0]  m_main = '0, m_shadow = '0, m_out = '0, m_flags = '0;
    logic          m_stall = 1'b0;
    logic [CW-1:0] m_cnt = '0;

    timing_err_detector #(.DATA_W(W), .MONITOR_MASK(MASK), .CNT_W(CW)) dut (
        .clk(clk), .clk_dly(clk_dly), .rst_n(rst_n), .data_in(data_in),
        .cnt_clr(cnt_clr), .data_out(data_out), .err_bits(err_bits),
        .sys_err(sys_err), .vf_req(vf_req), .stall(stall), .err_cnt(err_cnt)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #DLY;
        forever #(CLK_PERIOD/2) clk_dly = ~clk_dly;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Requirement-level behaviour at one rising edge.
    task automatic model_edge(input logic [W-1:0] d, input bit clr, input bit rst);
        logic [W-1:0] mm;
        if (rst) begin
            m_main = '0; m_out = '0; m_flags = '0; m_stall = 1'b0; m_cnt = '0;
        end else begin
            mm = m_stall ? '0 : ((m_main ^ m_shadow) & MASK);
            if (clr) m_cnt = '0;
            else if ((|m_flags) && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
            if (mm == '0) m_out = m_main;
            m_main  = (mm != '0) ? ((m_main & ~MASK) | (m_shadow & MASK)) : d;
            m_flags = mm;
            m_stall = (mm != '0);
        end
    endtask

    task automatic compare_all();
        check("R1/R6 data_out", 32'(data_out), 32'(m_out));
        check("R3 err_bits", 32'(err_bits), 32'(m_flags));
        check("R4 unmonitored flag", 32'(err_bits[6]), 32'd0);
        check("R5 sys_err", 32'(sys_err), 32'(|m_flags));
        check("R5 vf_req", 32'(vf_req), 32'(|m_flags));
        check("R7 stall", 32'(stall), 32'(m_stall));
        check("R8/R9 err_cnt", 32'(err_cnt), 32'(m_cnt));
    endtask

    // One cycle: drive before the edge, optional late change in the window.
    task automatic step(input logic [W-1:0] early, input logic [W-1:0] late,
                        input bit is_late, input bit clr, input bit rst);
        data_in = early; cnt_clr = clr; rst_n = !rst;
        @(posedge clk);
        model_edge(early, clr, rst);
        #3;
        if (is_late) data_in = late;   // R2: change while clk_dly is high
        #5;
        m_shadow = rst ? '0 : data_in;
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] e;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        // R10: reset state
        step(8'hA5, 8'hA5, 0, 0, 1);
        step(8'h5A, 8'h00, 1, 0, 1);
        step(8'h00, 8'h00, 0, 0, 1);
        check("R10 reset data_out", 32'(data_out), 32'h0);
        check("R10 reset err_cnt", 32'(err_cnt), 32'h0);
        // R1: clean words
        step(8'h00, 8'h00, 0, 0, 0);
        step(8'h11, 8'h11, 0, 0, 0);
        step(8'h22, 8'h2A, 1, 0, 0);    // bit 3 arrives late
        check("R1 data_out", 32'(data_out), 32'h11);
        step(8'h33, 8'h33, 0, 0, 0);    // detection edge
        check("R6 held output", 32'(data_out), 32'h11);
        check("R3 flagged bit", 32'(err_bits), 32'h08);
        check("R7 stall high", 32'(stall), 32'h1);
        step(8'h44, 8'h44, 0, 0, 0);    // correction released
        check("R7 corrected out", 32'(data_out), 32'h2A);
        check("R7 stall low", 32'(stall), 32'h0);
        check("R7 flags cleared", 32'(err_bits), 32'h0);
        step(8'h55, 8'h55, 0, 0, 0);
        check("R1 next word", 32'(data_out), 32'h44);
        // R4: late flip only on unmonitored bit 6
        step(8'h01, 8'h41, 1, 0, 0);
        step(8'h02, 8'h02, 0, 0, 0);
        check("R4 no error", 32'(sys_err), 32'h0);
        // R7: mismatch during the correction cycle is ignored
        step(8'h10, 8'h90, 1, 0, 0);
        step(8'h20, 8'h21, 1, 0, 0);
        step(8'h30, 8'h30, 0, 0, 0);
        check("R7 no compare in stall", 32'(sys_err), 32'h0);
        // R8: saturation
        for (int k = 0; k < 40; k++) begin
            step(8'h0F, 8'h8F, 1, 0, 0);
            step(8'h0F, 8'h0F, 0, 0, 0);
        end
        step(8'h0F, 8'h0F, 0, 0, 0);
        check("R8 saturated", 32'(err_cnt), 32'(CMAX));
        // R9: clear
        step(8'h0F, 8'h0F, 0, 1, 0);
        check("R9 cleared", 32'(err_cnt), 32'h0);
        // Random mix
        for (int k = 0; k < 600; k++) begin
            e = W'($urandom);
            step(e, e ^ W'(1 << ($urandom % W)), ($urandom % 4) == 0,
                 ($urandom % 50) == 0, ($urandom % 100) == 0);
        end
        // R10: reset mid-run
        step(8'hFF, 8'h7F, 1, 0, 0);
        step(8'hFF, 8'hFF, 0, 0, 1);
        check("R10 mid-run stall", 32'(stall), 32'h0);
        check("R10 mid-run out", 32'(data_out), 32'h0);
        step(8'h00, 8'h00, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule